// File: doc/BRIEF.md
# Byte Register File with Pair Operations

This block holds an accumulator and six general byte registers (B, C, D, E, H, L). It pairs them into three 16-bit words: BC, DE and HL. The high byte of each pair is the first letter, so B, D and H are the high bytes. A single op code selects one operation per cycle. The operations are:

- a byte write to one register;
- a 16-bit immediate load into a pair;
- pair increment and pair decrement;
- an exchange of DE with HL;
- a 16-bit add of a pair into HL. This add drives the carry output.

The HL pair also serves as the address of the indirect memory operand. A byte write with destination code 6 goes to memory at HL, and a read with code 6 returns the memory byte at HL. Two further operations move HL to or from memory over a byte-wide port. The memory port reads combinationally and writes on the clock edge. These operations use two consecutive addresses: the low byte (L) sits at the lower address and the high byte (H) at the next one. Each takes two cycles. `busy` is high during the second cycle, and the port ignores any new op code while `busy` is high.

Top module: `regpair_file`

## Requirements
- R1: Reset clears every register and the carry output, drops `busy`, and leaves `mem_we` and `mem_re` low.
- R2: Op 1 writes `wr_byte` into the register named by `dst_sel` (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A). From the next cycle, `rd_data` returns that value for the same code on `rd_sel`.
- R3: Register code 6 names memory at HL. Op 1 with `dst_sel`=6 asserts `mem_we` in the same cycle, with `mem_addr`=HL and `mem_wdata`=`wr_byte`. When no memory sequence is running, `mem_addr` shows HL and `rd_sel`=6 returns `mem_rdata`.
- R4: Op 2 loads `imm` into the pair named by `pair_sel` (0 BC, 1 DE, 2 HL). `imm[15:8]` goes to the high register.
- R5: Op 3 adds one to the selected pair and op 4 subtracts one, both modulo 2^16. Neither changes `carry`.
- R6: Op 5 exchanges H with D and L with E in one cycle.
- R7: Op 6 writes HL plus the selected pair into HL and sets `carry` to bit 16 of the sum. No other op changes `carry`.
- R8: Op 7 (load HL) reads in two cycles. In the issue cycle it asserts `mem_re` at `imm` and loads L from `mem_rdata`. In the next cycle `busy` is high and it asserts `mem_re` at `imm`+1 modulo 2^16, then loads H. Memory is not written.
- R9: Op 8 (store HL) writes in two cycles. In the issue cycle it asserts `mem_we` at `imm` with L as data. In the next cycle `busy` is high and it asserts `mem_we` at `imm`+1 modulo 2^16 with H as data.
- R10: An op code presented while `busy` is high has no effect. `busy` is never high for two cycles in a row.
- R11: With `pair_sel`=3, ops 2, 3, 4 and 6 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 4 | Operation code |
| dst_sel | input | 3 | Byte write destination |
| pair_sel | input | 2 | Pair select |
| wr_byte | input | 8 | Byte write data |
| imm | input | 16 | Immediate word / direct address |
| rd_sel | input | 3 | Byte read select |
| rd_data | output | 8 | Byte read data |
| carry | output | 1 | Carry from the pair add |
| busy | output | 1 | Second cycle of a two-byte memory sequence |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data |

## Verification
Memory strobes, address and write data are combinational. The bench samples them 1 ns after it drives an op, before the next clock edge. Register contents and `carry` change on the edge that accepts the op, so the bench reads them through `rd_data` 1 ns after that edge. In the two-byte sequences L is due after the first edge and H after the second. `busy` is checked in the cycle between those edges, and an op is presented there to confirm that it has no effect.

// File: rtl/regpair_file.sv
module regpair_file #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op,
  input  logic [2:0]      dst_sel,
  input  logic [1:0]      pair_sel,
  input  logic [DW-1:0]   wr_byte,
  input  logic [2*DW-1:0] imm,
  input  logic [2:0]      rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic            carry,
  output logic            busy,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int AW = 2 * DW;
  localparam logic [3:0] OP_WRB = 4'd1, OP_LDW = 4'd2, OP_INC = 4'd3, OP_DEC = 4'd4,
                         OP_XCH = 4'd5, OP_ADD = 4'd6, OP_LHL = 4'd7, OP_SHL = 4'd8;
  localparam logic [2:0] IX_D = 3'd2, IX_E = 3'd3, IX_H = 3'd4, IX_L = 3'd5, IX_M = 3'd6;

  logic [DW-1:0] rf [8];
  logic          store_q;
  logic [AW-1:0] next_q;

  wire [2:0]    hi_ix   = {pair_sel, 1'b0};
  wire [2:0]    lo_ix   = {pair_sel, 1'b1};
  wire          pair_ok = pair_sel != 2'd3;
  wire [AW-1:0] pv      = {rf[hi_ix], rf[lo_ix]};
  wire [AW-1:0] hl      = {rf[IX_H], rf[IX_L]};
  wire [AW:0]   sum     = {1'b0, pv} + {1'b0, hl};

  assign rd_data = (rd_sel == IX_M) ? mem_rdata : rf[rd_sel];

  always_comb begin
    mem_addr  = hl;
    mem_wdata = wr_byte;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    if (busy) begin
      mem_addr = next_q;
      if (store_q) begin
        mem_we    = 1'b1;
        mem_wdata = rf[IX_H];
      end else begin
        mem_re = 1'b1;
      end
    end else begin
      case (op)
        OP_WRB: mem_we = (dst_sel == IX_M);
        OP_LHL: begin
          mem_addr = imm;
          mem_re   = 1'b1;
        end
        OP_SHL: begin
          mem_addr  = imm;
          mem_we    = 1'b1;
          mem_wdata = rf[IX_L];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      carry   <= 1'b0;
      busy    <= 1'b0;
      store_q <= 1'b0;
      next_q  <= '0;
    end else if (busy) begin
      busy <= 1'b0;
      if (!store_q) rf[IX_H] <= mem_rdata;
    end else begin
      case (op)
        OP_WRB: if (dst_sel != IX_M) rf[dst_sel] <= wr_byte;
        OP_LDW: if (pair_ok) {rf[hi_ix], rf[lo_ix]} <= imm;
        OP_INC: if (pair_ok) {rf[hi_ix], rf[lo_ix]} <= pv + 1'b1;
        OP_DEC: if (pair_ok) {rf[hi_ix], rf[lo_ix]} <= pv - 1'b1;
        OP_XCH: begin
          rf[IX_D] <= rf[IX_H];
          rf[IX_E] <= rf[IX_L];
          rf[IX_H] <= rf[IX_D];
          rf[IX_L] <= rf[IX_E];
        end
        OP_ADD: if (pair_ok) begin
          {rf[IX_H], rf[IX_L]} <= sum[AW-1:0];
          carry <= sum[AW];
        end
        OP_LHL: begin
          rf[IX_L] <= mem_rdata;
          busy     <= 1'b1;
          store_q  <= 1'b0;
          next_q   <= imm + 1'b1;
        end
        OP_SHL: begin
          busy    <= 1'b1;
          store_q <= 1'b1;
          next_q  <= imm + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module regpair_file_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op,
  input logic          busy,
  input logic          carry,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr
);
  a_r1_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r10_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r8_seq_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (op == 4'd7 || op == 4'd8)) |=> busy);

  a_r9_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mem_we || mem_re)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r7_carry_only_add: assert property (@(posedge clk) disable iff (!rst_n)
    (carry != $past(carry)) |-> ($past(op) == 4'd6 && !$past(busy)));
endmodule

bind regpair_file regpair_file_chk #(.AW(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .busy(busy), .carry(carry),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/regpair_file_test.sv
`timescale 1ns/1ps
module regpair_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [2:0]  dst_sel = '0;
  logic [1:0]  pair_sel = '0;
  logic [7:0]  wr_byte = '0;
  logic [15:0] imm = '0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data, mem_wdata, mem_rdata;
  logic        carry, busy, mem_we, mem_re;
  logic [15:0] mem_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  mem [256];
  logic [15:0] wl_a [16];
  logic [7:0]  wl_d [16];
  int          wn = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) begin
    mem[mem_addr[7:0]] <= mem_wdata;
    wl_a[wn[3:0]] <= mem_addr;
    wl_d[wn[3:0]] <= mem_wdata;
    wn <= wn + 1;
  end

  regpair_file uut (
    .clk(clk), .rst_n(rst_n), .op(op), .dst_sel(dst_sel), .pair_sel(pair_sel),
    .wr_byte(wr_byte), .imm(imm), .rd_sel(rd_sel), .rd_data(rd_data),
    .carry(carry), .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // {pair_sel, pair value, HL value, expected HL, expected carry}
  localparam logic [50:0] VEC [5] = '{
    {2'd0, 16'h1234, 16'h1111, 16'h2345, 1'b0},
    {2'd1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h8000, 16'h0000, 1'b1},
    {2'd0, 16'h00FF, 16'h0001, 16'h0100, 1'b0},
    {2'd1, 16'hC000, 16'hC000, 16'h8000, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [2:0] d, input logic [1:0] p,
                       input logic [7:0] w, input logic [15:0] i);
    op = o; dst_sel = d; pair_sel = p; wr_byte = w; imm = i;
    @(posedge clk); #1;
    op = 4'd0;
  endtask

  task automatic rd_byte(input logic [2:0] s, output logic [7:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic rd_pair(input logic [1:0] p, output logic [15:0] v);
    logic [7:0] h, l;
    rd_byte({p, 1'b0}, h);
    rd_byte({p, 1'b1}, l);
    v = {h, l};
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, w2;
    int          n0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #1;
    // R1 reset state, sampled while reset is active
    for (int s = 0; s < 8; s++) if (s != 6) begin
      rd_byte(3'(s), b);
      chk("R1 reset reg", {8'h0, b}, 16'h0);
    end
    chk("R1 reset flags", {12'h0, carry, busy, mem_we, mem_re}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 byte writes
    for (int s = 0; s < 8; s++) if (s != 6) issue(4'd1, 3'(s), 2'd0, 8'h10 + 8'(s), 16'h0);
    for (int s = 0; s < 8; s++) if (s != 6) begin
      rd_byte(3'(s), b);
      chk("R2 byte write", {8'h0, b}, {8'h0, 8'h10 + 8'(s)});
    end

    // R4 word loads, high byte first register
    issue(4'd2, 3'd0, 2'd0, 8'h0, 16'hA1B2);
    issue(4'd2, 3'd0, 2'd1, 8'h0, 16'hC3D4);
    issue(4'd2, 3'd0, 2'd2, 8'h0, 16'h0010);
    rd_byte(3'd0, b); chk("R4 B high", {8'h0, b}, 16'h00A1);
    rd_byte(3'd3, b); chk("R4 E low", {8'h0, b}, 16'h00D4);
    rd_pair(2'd2, w); chk("R4 HL", w, 16'h0010);

    // R3 memory operand at HL
    op = 4'd1; dst_sel = 3'd6; wr_byte = 8'h3C; #1;
    chk("R3 write strobe", {15'h0, mem_we}, 16'h1);
    chk("R3 write addr", mem_addr, 16'h0010);
    chk("R3 write data", {8'h0, mem_wdata}, 16'h003C);
    @(posedge clk); #1; op = 4'd0;
    issue(4'd2, 3'd0, 2'd2, 8'h0, 16'h0011);
    issue(4'd1, 3'd6, 2'd0, 8'hA5, 16'h0);
    issue(4'd3, 3'd0, 2'd2, 8'h0, 16'h0);
    rd_byte(3'd6, b); chk("R3 read at HL", {8'h0, b}, 16'h0000);
    issue(4'd4, 3'd0, 2'd2, 8'h0, 16'h0);
    chk("R3 idle addr", mem_addr, 16'h0011);
    rd_byte(3'd6, b); chk("R3 read at HL", {8'h0, b}, 16'h00A5);

    // R7 vector table for the pair add
    for (int k = 0; k < 5; k++) begin
      if (VEC[k][50:49] != 2'd2) issue(4'd2, 3'd0, VEC[k][50:49], 8'h0, VEC[k][48:33]);
      issue(4'd2, 3'd0, 2'd2, 8'h0, VEC[k][32:17]);
      issue(4'd6, 3'd0, VEC[k][50:49], 8'h0, 16'h0);
      rd_pair(2'd2, w); chk("R7 sum", w, VEC[k][16:1]);
      chk("R7 carry", {15'h0, carry}, {15'h0, VEC[k][0]});
      if (VEC[k][50:49] != 2'd2) begin
        rd_pair(VEC[k][50:49], w); chk("R7 source pair kept", w, VEC[k][48:33]);
      end
    end

    // R5 wrap both ways, carry (now 1) untouched
    issue(4'd2, 3'd0, 2'd0, 8'h0, 16'hFFFF);
    issue(4'd3, 3'd0, 2'd0, 8'h0, 16'h0);
    rd_pair(2'd0, w); chk("R5 inc wrap", w, 16'h0000);
    issue(4'd4, 3'd0, 2'd0, 8'h0, 16'h0);
    issue(4'd4, 3'd0, 2'd0, 8'h0, 16'h0);
    rd_pair(2'd0, w); chk("R5 dec wrap", w, 16'hFFFE);
    issue(4'd3, 3'd0, 2'd1, 8'h0, 16'h0);
    rd_pair(2'd1, w); chk("R5 inc DE", w, 16'hC001);
    chk("R5 carry kept", {15'h0, carry}, 16'h1);

    // R6 exchange
    issue(4'd2, 3'd0, 2'd1, 8'h0, 16'h1357);
    issue(4'd2, 3'd0, 2'd2, 8'h0, 16'h2468);
    issue(4'd5, 3'd0, 2'd0, 8'h0, 16'h0);
    rd_pair(2'd1, w); rd_pair(2'd2, w2);
    chk("R6 DE after swap", w, 16'h2468);
    chk("R6 HL after swap", w2, 16'h1357);

    // R11 pair code 3 ignored
    issue(4'd2, 3'd0, 2'd3, 8'h0, 16'h5555);
    issue(4'd3, 3'd0, 2'd3, 8'h0, 16'h0);
    issue(4'd6, 3'd0, 2'd3, 8'h0, 16'h0);
    rd_byte(3'd7, b); chk("R11 A kept", {8'h0, b}, 16'h0017);
    rd_pair(2'd2, w); chk("R11 HL kept", w, 16'h1357);
    rd_pair(2'd0, w); chk("R11 BC kept", w, 16'hFFFE);
    chk("R11 carry kept", {15'h0, carry}, 16'h1);

    // R8 load HL from 0x0010/0x0011, with an op during busy (R10)
    op = 4'd7; imm = 16'h0010; #1;
    chk("R8 first read", {mem_addr[14:0], mem_re}, {15'h0010, 1'b1});
    @(posedge clk); #1;
    op = 4'd1; dst_sel = 3'd7; wr_byte = 8'hEE; #1;
    chk("R8 busy", {15'h0, busy}, 16'h1);
    chk("R8 second addr", mem_addr, 16'h0011);
    chk("R8 second strobe", {14'h0, mem_re, mem_we}, 16'h2);
    rd_byte(3'd5, b); chk("R8 L loaded", {8'h0, b}, 16'h003C);
    @(posedge clk); #1; op = 4'd0;
    rd_pair(2'd2, w); chk("R8 HL loaded", w, 16'hA53C);
    chk("R8 busy low", {15'h0, busy}, 16'h0);
    rd_byte(3'd7, b); chk("R10 A kept", {8'h0, b}, 16'h0017);

    // R9 store HL at 0xFFFF with wrap to 0x0000
    n0 = wn;
    issue(4'd2, 3'd0, 2'd2, 8'h0, 16'h9A78);
    op = 4'd8; imm = 16'hFFFF; #1;
    chk("R9 first write", {mem_addr[14:0], mem_we}, {15'h7FFF, 1'b1});
    @(posedge clk); #1;
    op = 4'd2; pair_sel = 2'd2; imm = 16'h0000; #1;
    chk("R9 busy", {15'h0, busy}, 16'h1);
    @(posedge clk); #1; op = 4'd0;
    chk("R9 write count", 16'(wn - n0), 16'd2);
    chk("R9 low addr", wl_a[n0[3:0]], 16'hFFFF);
    chk("R9 low data", {8'h0, wl_d[n0[3:0]]}, 16'h0078);
    chk("R9 high addr", wl_a[4'(n0 + 1)], 16'h0000);
    chk("R9 high data", {8'h0, wl_d[4'(n0 + 1)]}, 16'h009A);
    rd_pair(2'd2, w); chk("R10 HL kept", w, 16'h9A78);

    // R1 reset again clears state
    rst_n = 1'b0; #1;
    rd_pair(2'd2, w); chk("R1 reset again", w, 16'h0);
    chk("R1 carry cleared", {15'h0, carry}, 16'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule